// File: doc/BRIEF.md
# Framed Serial Transmitter with Line-Busy Status

This block turns bytes into asynchronous serial frames on a single output line. Characters go into a small first-in first-out store through a one-cycle write strobe. When transmission is allowed, the block takes the oldest character and shifts out its frame: a low start bit, five to eight data bits starting with the least significant, an optional parity bit, and one or two high stop bits. All bit timing comes from an enable pulse at sixteen times the bit rate, so each bit lasts sixteen of those pulses.

The frame format is set by a group of static control inputs. The block samples them when it takes a character from the store, so each frame has one consistent format. Characters follow each other with no idle gap until the store is empty. Two status outputs report the state of the store, and a busy output reports the state of the line. Busy stays high until the store is empty and the last stop bit of the last character has been on the line for its full sixteen pulses.

Top module: `serial_tx_core`

## Requirements
- R1: After reset the line is high, the empty flag is 1, the full flag is 0 and busy is 0.
- R2: A frame starts with a low start bit, followed by 5 + `cfgWordLen` data bits sent least significant first (code 0 gives 5 bits, code 3 gives 8 bits). Every bit lasts exactly 16 `tickEn` pulses.
- R3: When `cfgParityEn` is 1, one parity bit follows the data bits. For even parity (`cfgParityOdd` = 0) it is the XOR of the data bits sent. For odd parity it is the inverse of that XOR. Data bits above the configured length never affect it.
- R4: One high stop bit ends each frame, or two when `cfgTwoStop` is 1. Each stop bit lasts 16 pulses.
- R5: Stored characters are sent in write order, back to back, until the store is empty. Then the empty flag returns to 1.
- R6: `busy` is 1 from the cycle after an accepted write until the store is empty and the last stop bit has been fully sent. The cycle after that it is 0. While `busy` is 0 the line is high.
- R7: While `txEnable` is 0, no new frame starts and the line stays high. Stored characters are kept and busy stays 1. A frame already under way still completes.
- R8: With `DEPTH` characters stored, `fifoFull` is 1 and a further write is dropped. It changes neither the stored contents nor the frame in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Enable pulse at 16x the bit rate |
| txEnable | input | 1 | Allows new frames to start |
| wrValid | input | 1 | Write strobe for the character store |
| wrData | input | 8 | Character to store |
| cfgWordLen | input | 2 | Data length code, length = 5 + code |
| cfgParityEn | input | 1 | Adds a parity bit |
| cfgParityOdd | input | 1 | 1 = odd parity, 0 = even parity |
| cfgTwoStop | input | 1 | 1 = two stop bits |
| txLine | output | 1 | Serial output, high when idle |
| fifoEmpty | output | 1 | Store holds no characters |
| fifoFull | output | 1 | Store holds DEPTH characters |
| busy | output | 1 | Store non-empty or a frame is on the line |

## Verification
The assertions check, on every cycle, that the line is high whenever busy is low and that an accepted write raises busy on the next cycle. They also check that a full store keeps its fill level when a write arrives without a pop, that the controller never pops an empty store, and that a disabled idle transmitter stays idle. Frame content, bit duration, parity value, stop count and ordering can only be seen by the bench's line decoder, which compares each frame with the scoreboard. The same holds for the exact cycle busy falls and for a frame that completes after the enable drops.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } txState_e;

  typedef enum logic [1:0] {
    LINE_MARK,
    LINE_SPACE,
    LINE_DATA,
    LINE_PARITY
  } lineSel_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic     pop;
    logic     shift;
    lineSel_e lineSel;
  } txStrobe_t;

endpackage

// File: rtl/serial_tx_dpath.sv
module serial_tx_dpath
  import serial_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MIN_W  = 5,
  parameter int DEPTH  = 4,
  parameter int LEN_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic [LEN_W-1:0]  wordLen,
  input  logic              parityOdd,
  input  txStrobe_t         strobe,
  output logic              fifoEmpty,
  output logic              fifoFull,
  output logic              txLine
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  rdPtr, wrPtr;
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] shiftReg;
  logic              parityBit;
  logic              wrAccept;
  logic [DATA_W-1:0] lenMask;

  function automatic logic [PTR_W-1:0] ptrInc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign fifoEmpty = (count == '0);
  assign fifoFull  = (count == CNT_W'(DEPTH));
  assign wrAccept  = wrValid && !fifoFull;

  always_comb begin
    lenMask = '0;
    for (int i = 0; i < DATA_W; i++)
      lenMask[i] = (i < MIN_W + int'(wordLen));
  end

  always_ff @(posedge clk) begin
    if (wrAccept) store[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr     <= '0;
      wrPtr     <= '0;
      count     <= '0;
      shiftReg  <= '0;
      parityBit <= 1'b0;
    end else begin
      if (wrAccept) wrPtr <= ptrInc(wrPtr);
      if (strobe.pop) begin
        rdPtr     <= ptrInc(rdPtr);
        shiftReg  <= store[rdPtr];
        parityBit <= (^(store[rdPtr] & lenMask)) ^ parityOdd;
      end else if (strobe.shift) begin
        shiftReg <= shiftReg >> 1;
      end
      count <= count + CNT_W'(wrAccept) - CNT_W'(strobe.pop);
    end
  end

  always_comb begin
    case (strobe.lineSel)
      LINE_SPACE:  txLine = 1'b0;
      LINE_DATA:   txLine = shiftReg[0];
      LINE_PARITY: txLine = parityBit;
      default:     txLine = 1'b1;
    endcase
  end

  // R8: a write into a full store without a pop leaves the level unchanged
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull && wrValid && !strobe.pop |=> $stable(count) && fifoFull);

  // R5: the sequencer only pops a store that holds something
  p_pop_nonempty_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> !fifoEmpty);

endmodule

// File: rtl/serial_tx_ctrl.sv
module serial_tx_ctrl
  import serial_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MIN_W  = 5,
  parameter int TICKS  = 16,
  parameter int LEN_W  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             txEnable,
  input  logic             fifoEmpty,
  input  logic [LEN_W-1:0] wordLen,
  input  logic             parityEn,
  input  logic             twoStop,
  output txStrobe_t        strobe,
  output logic             active
);

  localparam int TICK_W = $clog2(TICKS);
  localparam int BIT_W  = $clog2(DATA_W);

  txState_e          state, stateN;
  logic [TICK_W-1:0] tickCnt;
  logic [BIT_W-1:0]  bitCnt, lastIdx;
  logic              parEnL, twoStopL;
  logic              bitEnd, stopDone, canStart;

  assign bitEnd   = tickEn && (tickCnt == TICK_W'(TICKS - 1));
  assign stopDone = (state == ST_STOP) && bitEnd && (!twoStopL || bitCnt != '0);
  assign canStart = txEnable && !fifoEmpty && (state == ST_IDLE || stopDone);
  assign active   = (state != ST_IDLE);

  always_comb begin
    stateN         = state;
    strobe.pop     = canStart;
    strobe.shift   = 1'b0;
    strobe.lineSel = LINE_MARK;
    case (state)
      ST_START:  strobe.lineSel = LINE_SPACE;
      ST_DATA:   strobe.lineSel = LINE_DATA;
      ST_PARITY: strobe.lineSel = LINE_PARITY;
      default:   strobe.lineSel = LINE_MARK;
    endcase
    if (canStart) begin
      stateN = ST_START;
    end else if (bitEnd) begin
      case (state)
        ST_START: stateN = ST_DATA;
        ST_DATA: begin
          strobe.shift = 1'b1;
          if (bitCnt == lastIdx) stateN = parEnL ? ST_PARITY : ST_STOP;
        end
        ST_PARITY: stateN = ST_STOP;
        ST_STOP:   if (stopDone) stateN = ST_IDLE;
        default:   stateN = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      tickCnt  <= '0;
      bitCnt   <= '0;
      lastIdx  <= '0;
      parEnL   <= 1'b0;
      twoStopL <= 1'b0;
    end else begin
      state <= stateN;
      if (canStart || state == ST_IDLE) tickCnt <= '0;
      else if (tickEn) tickCnt <= bitEnd ? '0 : tickCnt + 1'b1;
      if (canStart) begin
        bitCnt   <= '0;
        lastIdx  <= BIT_W'(MIN_W - 1) + BIT_W'(wordLen);
        parEnL   <= parityEn;
        twoStopL <= twoStop;
      end else if (bitEnd) begin
        if (state == ST_DATA)      bitCnt <= (bitCnt == lastIdx) ? '0 : bitCnt + 1'b1;
        else if (state == ST_STOP) bitCnt <= bitCnt + 1'b1;
        else                       bitCnt <= '0;
      end
    end
  end

  // R7: a disabled idle transmitter does not start a frame
  p_hold_disabled_r7: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_IDLE && !txEnable |=> state == ST_IDLE);

  // R2: the data bit index never passes the configured length
  p_data_len_r2: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_DATA |-> bitCnt <= lastIdx);

endmodule

// File: rtl/serial_tx_core.sv
module serial_tx_core
  import serial_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MIN_W  = 5,
  parameter int DEPTH  = 4,
  parameter int TICKS  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              txEnable,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        cfgWordLen,
  input  logic              cfgParityEn,
  input  logic              cfgParityOdd,
  input  logic              cfgTwoStop,
  output logic              txLine,
  output logic              fifoEmpty,
  output logic              fifoFull,
  output logic              busy
);

  txStrobe_t strobe;
  logic      active;

  serial_tx_ctrl #(.DATA_W(DATA_W), .MIN_W(MIN_W), .TICKS(TICKS), .LEN_W(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .txEnable(txEnable),
    .fifoEmpty(fifoEmpty), .wordLen(cfgWordLen), .parityEn(cfgParityEn),
    .twoStop(cfgTwoStop), .strobe(strobe), .active(active)
  );

  serial_tx_dpath #(.DATA_W(DATA_W), .MIN_W(MIN_W), .DEPTH(DEPTH), .LEN_W(2)) u_dpath (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData),
    .wordLen(cfgWordLen), .parityOdd(cfgParityOdd), .strobe(strobe),
    .fifoEmpty(fifoEmpty), .fifoFull(fifoFull), .txLine(txLine)
  );

  assign busy = !fifoEmpty || active;

  // R6: an idle block holds the line high
  p_idle_mark_r6: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txLine);

  // R6: an accepted write raises busy on the next cycle
  p_busy_on_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && !fifoFull |=> busy);

endmodule

// File: tb/sim_serial_tx_core.sv
module sim_serial_tx_core;

  localparam int TDIV  = 3;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rstN = 1'b0, tickEn = 1'b0, txEnable = 1'b0, wrValid = 1'b0;
  logic [7:0] wrData = '0;
  logic [1:0] cfgWordLen = 2'd3;
  logic       cfgParityEn = 1'b0, cfgParityOdd = 1'b0, cfgTwoStop = 1'b0;
  logic       txLine, fifoEmpty, fifoFull, busy;

  serial_tx_core #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .txEnable(txEnable),
    .wrValid(wrValid), .wrData(wrData), .cfgWordLen(cfgWordLen),
    .cfgParityEn(cfgParityEn), .cfgParityOdd(cfgParityOdd), .cfgTwoStop(cfgTwoStop),
    .txLine(txLine), .fifoEmpty(fifoEmpty), .fifoFull(fifoFull), .busy(busy)
  );

  typedef struct {
    logic [7:0] data;
    int         nBits;
    bit         parEn;
    bit         parOdd;
    bit         twoStop;
  } item_t;

  item_t expQ[$];
  int    checks = 0, fails = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // 16x enable: one pulse every TDIV cycles
  int tickDiv = 0;
  always @(posedge clk) begin
    #1;
    if (tickDiv == TDIV - 1) begin tickDiv = 0; tickEn = 1'b1; end
    else begin tickDiv++; tickEn = 1'b0; end
  end

  // driver: write one character, queue it if the store should accept it
  task automatic pushByte(input logic [7:0] d, input bit accept);
    item_t it;
    @(posedge clk); #1;
    wrValid = 1'b1;
    wrData  = d;
    if (accept) begin
      it.nBits   = 5 + int'(cfgWordLen);
      it.data    = d & 8'((1 << it.nBits) - 1);
      it.parEn   = cfgParityEn;
      it.parOdd  = cfgParityOdd;
      it.twoStop = cfgTwoStop;
      expQ.push_back(it);
    end
    @(posedge clk); #1;
    wrValid = 1'b0;
  endtask

  function automatic logic expBit(input item_t it, input int b);
    if (b == 0) return 1'b0;
    if (b <= it.nBits) return it.data[b-1];
    if (it.parEn && b == it.nBits + 1) return (^it.data) ^ it.parOdd;
    return 1'b1;
  endfunction

  // monitor: decode frames off the line, compare with the scoreboard
  bit    inFrame = 0, checkBusyNow = 0, bad = 0, busyBad = 0;
  int    k = 0, total = 0;
  item_t cur;
  always @(negedge clk) begin
    if (rstN) begin
      if (!inFrame) begin
        if (checkBusyNow) begin
          checkBusyNow = 0;
          check(busy == (expQ.size() != 0), "R6", "busy after last stop", busy, expQ.size() != 0);
        end
        if (txLine == 1'b0) begin
          if (expQ.size() == 0) begin
            check(1'b0, "R5", "unexpected frame", 1, 0);
          end else begin
            cur = expQ.pop_front();
            inFrame = 1; k = 0; bad = 0; busyBad = 0;
            total = 1 + cur.nBits + (cur.parEn ? 1 : 0) + (cur.twoStop ? 2 : 1);
          end
        end
      end
      if (inFrame && tickEn) begin
        if (txLine !== expBit(cur, k / 16)) bad = 1;
        if (!busy) busyBad = 1;
        k++;
        if (k == 16 * total) begin
          inFrame = 0;
          checkBusyNow = 1;
          check(!bad, "R2 R3 R4", "frame content", int'(bad), 0);
          check(!busyBad, "R6", "busy during frame", int'(busyBad), 0);
        end
      end
    end
  end

  task automatic waitIdle();
    repeat (3) @(negedge clk);
    while (busy || inFrame) @(negedge clk);
    repeat (2) @(negedge clk);
    check(expQ.size() == 0, "R5", "frames left unsent", expQ.size(), 0);
    check(fifoEmpty == 1'b1, "R5", "empty flag after drain", fifoEmpty, 1);
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R5 watchdog expired actual=1 expected=0");
    finishRun();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(txLine == 1'b1, "R1", "line after reset", txLine, 1);
    check(fifoEmpty == 1'b1, "R1", "empty after reset", fifoEmpty, 1);
    check(fifoFull == 1'b0, "R1", "full after reset", fifoFull, 0);
    check(busy == 1'b0, "R1", "busy after reset", busy, 0);

    // R2 R5: eight bits, no parity, one stop, back to back
    @(posedge clk); #1 txEnable = 1'b1;
    pushByte(8'hA5, 1);
    pushByte(8'h3C, 1);
    waitIdle();

    // R3 R4: five bits, even parity, two stops; upper bits masked
    cfgWordLen = 2'd0; cfgParityEn = 1'b1; cfgParityOdd = 1'b0; cfgTwoStop = 1'b1;
    pushByte(8'hFF, 1);
    pushByte(8'h13, 1);
    waitIdle();

    // R3: seven bits, odd parity, one stop
    cfgWordLen = 2'd2; cfgParityOdd = 1'b1; cfgTwoStop = 1'b0;
    pushByte(8'h80, 1);
    pushByte(8'h55, 1);
    waitIdle();

    // R2 R4: six bits, even parity, two stops
    cfgWordLen = 2'd1; cfgParityOdd = 1'b0; cfgTwoStop = 1'b1;
    pushByte(8'h2A, 1);
    waitIdle();

    // R7: disable during a frame; that frame completes, the next waits
    cfgWordLen = 2'd3; cfgParityEn = 1'b0; cfgTwoStop = 1'b0;
    pushByte(8'h11, 1);
    while (txLine) @(negedge clk);
    @(posedge clk); #1 txEnable = 1'b0;
    pushByte(8'h22, 1);
    @(negedge clk);
    check(busy == 1'b1, "R6", "busy after write", busy, 1);
    repeat (16 * 10 * TDIV + 300) @(negedge clk);
    check(txLine == 1'b1, "R7", "line while disabled", txLine, 1);
    check(fifoEmpty == 1'b0, "R7", "store kept while disabled", fifoEmpty, 0);
    check(busy == 1'b1, "R7", "busy while stored", busy, 1);
    check(expQ.size() == 1, "R7", "pending frames", expQ.size(), 1);
    @(posedge clk); #1 txEnable = 1'b1;
    waitIdle();

    // R8: fill while disabled, extra writes dropped
    @(posedge clk); #1 txEnable = 1'b0;
    for (int i = 0; i < DEPTH + 2; i++) pushByte(8'h40 + 8'(i), i < DEPTH);
    @(negedge clk);
    check(fifoFull == 1'b1, "R8", "full flag", fifoFull, 1);
    check(txLine == 1'b1, "R8", "line while full and disabled", txLine, 1);
    @(posedge clk); #1 txEnable = 1'b1;
    while (txLine) @(negedge clk);
    @(negedge clk);
    check(fifoFull == 1'b0, "R8", "full clears after pop", fifoFull, 0);
    waitIdle();

    finishRun();
  end

endmodule